// File: doc/BRIEF.md
# Registered command/address fan-out buffer

This block sits between a memory controller and a group of DRAM devices. On every rising clock edge it captures a command/address bus, two clock-enable controls, two on-die-termination controls and a set of chip-select lines. It then drives the captured values onto output copies: an A side and a B side for the shared bus and the controls, and a four-line chip-select output whose mapping depends on the select mode.

The select mode is taken from a mode pin while reset is held. With the pin high, two chip-select inputs are used and each one is driven to two output lines, so every captured bit fans out 1:2. With the pin low, all four chip-select inputs are used and each drives one output line 1:1, while the rest of the bus keeps its 1:2 fan-out. After reset is released the mode stays fixed until the next reset.

Top module: `cab_regbuf`

## Requirements
- R1: While reset is asserted, and after release until the first capture, every chip-select output is high (inactive), every clock-enable and termination output is low, and both command/address copies are zero.
- R2: Both `qa_ca` and `qb_ca` equal the value of `ca_in` that was sampled at the most recent rising clock edge.
- R3: `qa_cke`/`qb_cke` both equal the sampled `cke_in`, and `qa_odt`/`qb_odt` both equal the sampled `odt_in`.
- R4: In two-select mode (`quad_n` high during reset), `cs_q[0]` and `cs_q[2]` both carry sampled `cs_in[0]`, and `cs_q[1]` and `cs_q[3]` both carry sampled `cs_in[1]`.
- R5: In two-select mode, `cs_in[3:2]` has no effect on any output.
- R6: In four-select mode (`quad_n` low during reset), `cs_q[i]` carries sampled `cs_in[i]` for each i in 0 to 3.
- R7: The mode is taken only while reset is asserted; changing `quad_n` after release does not change the chip-select mapping.
- R8: Outputs change only at a rising clock edge; an input change between edges is not visible on the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| quad_n | input | 1 | Select-mode pin: high = two selects duplicated, low = four selects 1:1 |
| ca_in | input | CA_W | Command/address bus |
| cke_in | input | CTL_N | Clock-enable controls |
| odt_in | input | CTL_N | On-die-termination controls |
| cs_in | input | 2*SEL_N | Chip-select inputs, active low |
| qa_ca | output | CA_W | Command/address, A copy |
| qb_ca | output | CA_W | Command/address, B copy |
| qa_cke | output | CTL_N | Clock enables, A copy |
| qb_cke | output | CTL_N | Clock enables, B copy |
| qa_odt | output | CTL_N | Termination controls, A copy |
| qb_odt | output | CTL_N | Termination controls, B copy |
| cs_q | output | 2*SEL_N | Chip-select outputs, mapping set by the mode |

## Verification
Every captured result is due one rising edge after the inputs are applied: the driver sets inputs on a falling edge and queues the outputs the requirements predict, and the monitor pops that item a quarter period after the next rising edge. Just after each new input is applied, and before the next rising edge, the outputs are compared against the previous item to show that nothing moves between edges. The reset values are checked both while reset is held and in the two cycles of synchronised release before the first capture. The mode is fixed at reset release, so changing the mode pin mid-run must leave the expected chip-select mapping unchanged.

// File: rtl/cab_pkg.sv
package cab_pkg;

  typedef enum logic {
    MODE_QUAD = 1'b0,
    MODE_DUAL = 1'b1
  } cab_mode_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/cab_rst_sync.sv
module cab_rst_sync #(
  parameter int unsigned STAGES = cab_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/cab_mode_latch.sv
module cab_mode_latch
  import cab_pkg::*;
(
  input  logic      clk,
  input  logic      rst_sync_n,
  input  logic      quad_n,
  output cab_mode_e mode
);

  cab_mode_e mode_q;
  cab_mode_e mode_d;
  logic      mode_en;

  assign mode_en = !rst_sync_n;

  always_comb begin
    mode_d = quad_n ? MODE_DUAL : MODE_QUAD;
  end

  always_ff @(posedge clk) begin
    if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/cab_cs_map.sv
module cab_cs_map
  import cab_pkg::*;
#(
  parameter int unsigned SEL_N = 2,
  localparam int unsigned CS_W = 2 * SEL_N
) (
  input  cab_mode_e        mode,
  input  logic [CS_W-1:0]  cs_in,
  output logic [CS_W-1:0]  cs_next
);

  logic [CS_W-1:0] dual_map;

  genvar g;
  generate
    for (g = 0; g < SEL_N; g++) begin : g_dual
      assign dual_map[g]         = cs_in[g];
      assign dual_map[g + SEL_N] = cs_in[g];
    end
  endgenerate

  always_comb begin
    if (mode == MODE_QUAD) begin
      cs_next = cs_in;
    end else begin
      cs_next = dual_map;
    end
  end

endmodule

// File: rtl/cab_dupreg.sv
module cab_dupreg #(
  parameter int unsigned W      = 8,
  parameter int unsigned COPIES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic                       clk,
  input  logic                       rst_sync_n,
  input  logic [W-1:0]               d,
  output logic [COPIES-1:0][W-1:0]   q
);

  genvar c;
  generate
    for (c = 0; c < COPIES; c++) begin : g_copy
      logic [W-1:0] copy_q;
      logic [W-1:0] copy_d;

      always_comb begin
        copy_d = d;
      end

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
          copy_q <= RST_VAL;
        end else begin
          copy_q <= copy_d;
        end
      end

      assign q[c] = copy_q;
    end
  endgenerate

endmodule

// File: rtl/cab_regbuf.sv
module cab_regbuf
  import cab_pkg::*;
#(
  parameter int unsigned CA_W  = 22,
  parameter int unsigned CTL_N = 2,
  parameter int unsigned SEL_N = 2,
  localparam int unsigned CS_W = 2 * SEL_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             quad_n,
  input  logic [CA_W-1:0]  ca_in,
  input  logic [CTL_N-1:0] cke_in,
  input  logic [CTL_N-1:0] odt_in,
  input  logic [CS_W-1:0]  cs_in,
  output logic [CA_W-1:0]  qa_ca,
  output logic [CA_W-1:0]  qb_ca,
  output logic [CTL_N-1:0] qa_cke,
  output logic [CTL_N-1:0] qb_cke,
  output logic [CTL_N-1:0] qa_odt,
  output logic [CTL_N-1:0] qb_odt,
  output logic [CS_W-1:0]  cs_q
);

  localparam int unsigned SIDES = 2;

  logic                          rst_sync_n;
  cab_mode_e                     mode;
  logic [CS_W-1:0]               cs_next;
  logic [SIDES-1:0][CA_W-1:0]    ca_copies;
  logic [SIDES-1:0][CTL_N-1:0]   cke_copies;
  logic [SIDES-1:0][CTL_N-1:0]   odt_copies;
  logic [0:0][CS_W-1:0]          cs_reg;

  cab_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cab_mode_latch i_mode (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .quad_n     (quad_n),
    .mode       (mode)
  );

  cab_cs_map #(.SEL_N(SEL_N)) i_cs_map (
    .mode    (mode),
    .cs_in   (cs_in),
    .cs_next (cs_next)
  );

  cab_dupreg #(.W(CA_W), .COPIES(SIDES), .RST_VAL('0)) i_ca_reg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .d          (ca_in),
    .q          (ca_copies)
  );

  cab_dupreg #(.W(CTL_N), .COPIES(SIDES), .RST_VAL('0)) i_cke_reg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .d          (cke_in),
    .q          (cke_copies)
  );

  cab_dupreg #(.W(CTL_N), .COPIES(SIDES), .RST_VAL('0)) i_odt_reg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .d          (odt_in),
    .q          (odt_copies)
  );

  cab_dupreg #(.W(CS_W), .COPIES(1), .RST_VAL({CS_W{1'b1}})) i_cs_reg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .d          (cs_next),
    .q          (cs_reg)
  );

  assign qa_ca  = ca_copies[0];
  assign qb_ca  = ca_copies[1];
  assign qa_cke = cke_copies[0];
  assign qb_cke = cke_copies[1];
  assign qa_odt = odt_copies[0];
  assign qb_odt = odt_copies[1];
  assign cs_q   = cs_reg[0];

endmodule

// File: rtl/cab_regbuf_chk.sv
module cab_regbuf_chk #(
  parameter int unsigned CA_W  = 22,
  parameter int unsigned CTL_N = 2,
  parameter int unsigned SEL_N = 2,
  localparam int unsigned CS_W = 2 * SEL_N
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             mode_bit,
  input logic [CA_W-1:0]  ca_in,
  input logic [CTL_N-1:0] cke_in,
  input logic [CTL_N-1:0] odt_in,
  input logic [CS_W-1:0]  cs_in,
  input logic [CA_W-1:0]  qa_ca,
  input logic [CA_W-1:0]  qb_ca,
  input logic [CTL_N-1:0] qa_cke,
  input logic [CTL_N-1:0] qb_cke,
  input logic [CTL_N-1:0] qa_odt,
  input logic [CTL_N-1:0] qb_odt,
  input logic [CS_W-1:0]  cs_q
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (cs_q == {CS_W{1'b1}} && qa_cke == '0 && qb_cke == '0
                           && qa_odt == '0 && qb_odt == '0 && qa_ca == '0));

  assert_ca_copy_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (qa_ca == $past(ca_in) && qb_ca == $past(ca_in)));

  assert_ctl_copy_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (qa_cke == $past(cke_in) && qb_cke == $past(cke_in)
              && qa_odt == $past(odt_in) && qb_odt == $past(odt_in)));

  assert_pair_match_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_bit |-> (cs_q[SEL_N-1:0] == cs_q[CS_W-1:SEL_N]));

  assert_quad_map_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mode_bit |=> (cs_q == $past(cs_in)));

  assert_mode_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && $past(rst_sync_n)) |-> $stable(mode_bit));

endmodule

bind cab_regbuf cab_regbuf_chk #(.CA_W(CA_W), .CTL_N(CTL_N), .SEL_N(SEL_N)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .mode_bit   (mode),
  .ca_in      (ca_in),
  .cke_in     (cke_in),
  .odt_in     (odt_in),
  .cs_in      (cs_in),
  .qa_ca      (qa_ca),
  .qb_ca      (qb_ca),
  .qa_cke     (qa_cke),
  .qb_cke     (qb_cke),
  .qa_odt     (qa_odt),
  .qb_odt     (qb_odt),
  .cs_q       (cs_q)
);

// File: tb/test_cab_regbuf.sv
module test_cab_regbuf;

  localparam int CLK_P = 10;
  localparam int CA_W  = 22;
  localparam int CTL_N = 2;
  localparam int CS_W  = 4;

  logic             clk;
  logic             rst_n;
  logic             quad_n;
  logic [CA_W-1:0]  ca_in;
  logic [CTL_N-1:0] cke_in;
  logic [CTL_N-1:0] odt_in;
  logic [CS_W-1:0]  cs_in;
  logic [CA_W-1:0]  qa_ca, qb_ca;
  logic [CTL_N-1:0] qa_cke, qb_cke, qa_odt, qb_odt;
  logic [CS_W-1:0]  cs_q;

  int errors = 0;
  int checks = 0;
  logic mode_dual;

  logic [CA_W-1:0]  q_ca[$];
  logic [CTL_N-1:0] q_cke[$];
  logic [CTL_N-1:0] q_odt[$];
  logic [CS_W-1:0]  q_cs[$];
  string            q_tag[$];

  logic [CA_W-1:0]  last_ca;
  logic [CS_W-1:0]  last_cs;

  cab_regbuf i_cab_regbuf (
    .clk(clk), .rst_n(rst_n), .quad_n(quad_n),
    .ca_in(ca_in), .cke_in(cke_in), .odt_in(odt_in), .cs_in(cs_in),
    .qa_ca(qa_ca), .qb_ca(qb_ca), .qa_cke(qa_cke), .qb_cke(qb_cke),
    .qa_odt(qa_odt), .qb_odt(qb_odt), .cs_q(cs_q)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [CS_W-1:0] exp_cs(input logic dual, input logic [CS_W-1:0] c);
    exp_cs = dual ? {c[1], c[0], c[1], c[0]} : c;
  endfunction

  task automatic check_idle(input string tag);
    check(cs_q == 4'hF, {tag, " cs idle"}, 64'(cs_q), 64'hF);
    check(qa_cke == 0 && qb_cke == 0 && qa_odt == 0 && qb_odt == 0,
          {tag, " ctl idle"}, 64'({qa_cke, qb_cke, qa_odt, qb_odt}), 64'h0);
    check(qa_ca == 0 && qb_ca == 0, {tag, " ca idle"}, 64'({qa_ca, qb_ca}), 64'h0);
  endtask

  // Driver: apply at a falling edge, push the outputs due after the next rising edge.
  task automatic drive(input logic [CA_W-1:0] ca, input logic [CTL_N-1:0] cke,
                       input logic [CTL_N-1:0] odt, input logic [CS_W-1:0] cs,
                       input string tag);
    @(negedge clk);
    ca_in = ca; cke_in = cke; odt_in = odt; cs_in = cs;
    #1;
    // R8: no output movement between edges
    check(qa_ca == last_ca && cs_q == last_cs, "R8 hold between edges",
          64'({qa_ca, cs_q}), 64'({last_ca, last_cs}));
    q_ca.push_back(ca); q_cke.push_back(cke); q_odt.push_back(odt);
    q_cs.push_back(exp_cs(mode_dual, cs)); q_tag.push_back(tag);
    last_ca = ca;
    last_cs = exp_cs(mode_dual, cs);
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q_ca.size() > 0) begin
        logic [CA_W-1:0]  e_ca;
        logic [CTL_N-1:0] e_cke, e_odt;
        logic [CS_W-1:0]  e_cs;
        string            t;
        e_ca = q_ca.pop_front(); e_cke = q_cke.pop_front();
        e_odt = q_odt.pop_front(); e_cs = q_cs.pop_front(); t = q_tag.pop_front();
        check(qa_ca == e_ca && qb_ca == e_ca, "R2 ca copies",
              64'({qa_ca, qb_ca}), 64'({e_ca, e_ca}));
        check(qa_cke == e_cke && qb_cke == e_cke && qa_odt == e_odt && qb_odt == e_odt,
              "R3 ctl copies", 64'({qa_cke, qb_cke, qa_odt, qb_odt}),
              64'({e_cke, e_cke, e_odt, e_odt}));
        check(cs_q == e_cs, t, 64'(cs_q), 64'(e_cs));
      end
    end
  end

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst_n = 1'b0;
    quad_n = pin;
    ca_in = '0; cke_in = '0; odt_in = '0; cs_in = 4'hF;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 release");
    repeat (2) @(negedge clk);
    mode_dual = pin;
    last_ca = '0;
    last_cs = 4'hF;
  endtask

  initial begin
    rst_n = 1'b0; quad_n = 1'b1;
    ca_in = '0; cke_in = '0; odt_in = '0; cs_in = 4'hF;

    // Two-select mode
    do_reset(1'b1);
    drive(22'h2AAAAA, 2'b01, 2'b10, 4'b1110, "R4 dual sel0");
    drive(22'h155555, 2'b10, 2'b01, 4'b1101, "R4 dual sel1");
    drive(22'h000001, 2'b11, 2'b11, 4'b0011, "R5 upper selects ignored");
    drive(22'h3FFFFF, 2'b00, 2'b00, 4'b0100, "R5 upper selects ignored");
    drive(22'h123456, 2'b01, 2'b01, 4'b1000, "R4 dual both low");
    for (int i = 0; i < 6; i++) begin
      drive(22'(1 << (i * 3)), 2'(i), 2'(3 - i), 4'(i * 5), "R5 mixed pattern");
    end
    // Pin change after release: mapping stays two-select
    @(negedge clk);
    quad_n = 1'b0;
    drive(22'h0F0F0F, 2'b10, 2'b00, 4'b1001, "R7 pin low ignored");
    drive(22'h30F0F0, 2'b01, 2'b11, 4'b0110, "R7 pin low ignored");
    repeat (2) @(negedge clk);

    // Four-select mode
    do_reset(1'b0);
    drive(22'h0ABCDE, 2'b01, 2'b10, 4'b1110, "R6 quad sel0");
    drive(22'h1BCDEF, 2'b10, 2'b01, 4'b1011, "R6 quad sel2");
    drive(22'h2CDEF0, 2'b11, 2'b00, 4'b0111, "R6 quad sel3");
    drive(22'h3DEF01, 2'b00, 2'b11, 4'b0101, "R6 quad mix");
    @(negedge clk);
    quad_n = 1'b1;
    drive(22'h111111, 2'b01, 2'b01, 4'b0100, "R7 pin high ignored");
    drive(22'h222222, 2'b10, 2'b10, 4'b1100, "R7 pin high ignored");
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule